// File: doc/BRIEF.md
# Host Slave Parallel Port

This block lets an external host processor swap bytes with the local processor through a small mailbox. The mailbox has three parts: a byte buffer that the host writes (the inbound buffer), a byte buffer that the local side writes (the outbound buffer), and a status byte. The host side has an active-low chip select, active-low read and write strobes, one address line and an 8-bit data bus. It also has a DMA request output, an active-low DMA acknowledge input, and two full-flag pins. The local side is a simple register port with single-cycle read and write enables, a 2-bit register address, and one interrupt output.

On every host write, the block stores the level of the address line next to the byte. The local processor can then tell a command (address line high) from data (address line low). The inbound-full and outbound-full flags appear on pins and also in the status byte. The upper nibble of the status byte and one spare flag are written by local software and read by the host. A host read with the address line high returns the status byte. A host read with it low returns the outbound buffer.

A four-state machine handles host accesses, and each access is acted on once per strobe:
- **IDLE** waits for a strobe.
- **IDLE → WRITE** when a write strobe is seen while the port is selected. This transition captures the byte.
- **IDLE → RD_DATA** or **IDLE → RD_STAT** when a read strobe is seen, chosen by the address line.
- **WRITE, RD_DATA, RD_STAT → IDLE** when the strobe rises or the select is removed. Leaving **RD_DATA** empties the outbound buffer.

Top module: `hsp_port`

## Requirements
- R1: After reset, both full flags, the DMA request and the interrupt are low. The control register (local address 2) reads 0x00 and the status byte reads 0x00.
- R2: A host write (port selected, write strobe low) stores the data bus in the inbound buffer and sets the inbound-full flag (`hibf` and status bit 1) one clock later. Only one capture happens per strobe.
- R3: The level of `ha0` at the capturing edge is stored in status bit 3 (1 = command, 0 = data).
- R4: A local read of address 0 returns the inbound buffer and clears the inbound-full flag.
- R5: A local write to address 0 loads the outbound buffer and sets the outbound-full flag (`hobf`, status bit 0). A host read with `ha0` low returns that byte, and the flag clears when the read strobe rises.
- R6: A host read with `ha0` high returns the status byte: bits 7..4 general-purpose, bit 3 command tag, bit 2 spare flag, bit 1 inbound full, bit 0 outbound full. A local write to address 1 sets bits 7..4 and bit 2 from the same data bits.
- R7: The control bits are: bit 0 mode enable, bit 1 DMA enable, bit 2 inbound interrupt enable. With DMA enabled, `hdrq` is high exactly while the outbound buffer is full. With DMA enabled, a low `hdack_n` selects the port in place of `hcs_n`.
- R8: `lirq` is high while the inbound buffer is full and the interrupt enable bit is set. It stays low when that bit is clear.
- R9: The mode enable bit is always writable. The DMA and interrupt enable bits take a write only while mode enable is already 1.
- R10: While mode enable is 0, host strobes have no effect on the buffers or flags.
- R11: When a host write capture and a local read of the inbound buffer fall on the same edge, the read returns the old byte. The flag stays set, and the new byte is kept.
- R12: When a host data read ends on the same edge as a local write to the outbound buffer, the flag stays set and the new byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| ha0 | input | 1 | Host address line: command/status when high |
| hdack_n | input | 1 | DMA acknowledge, active low |
| hdin | input | 8 | Host write data |
| hdout | output | 8 | Host read data (status or outbound buffer) |
| hdrq | output | 1 | DMA request |
| hibf | output | 1 | Inbound buffer full |
| hobf | output | 1 | Outbound buffer full |
| lwr_en | input | 1 | Local write enable |
| lrd_en | input | 1 | Local read enable |
| laddr | input | 2 | Local register address (0 buffer, 1 status, 2 control) |
| lwdata | input | 8 | Local write data |
| lrdata | output | 8 | Local read data |
| lirq | output | 1 | Interrupt to local processor |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is the host write capture, which sets the inbound flag, and the local buffer read, which clears it. The second pair is the end of a host data read, which clears the outbound flag, and a local buffer write, which sets it. The bench provokes each pair by driving both stimuli at the same falling edge so that one rising edge acts on both. It then checks three things at the ports: that the flag is still set, that the local read returned the old byte, and that a later read returns the new byte.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
    localparam int DW   = 8;
    localparam int AW   = 2;
    localparam int STW  = DW - 4;

    typedef enum logic [1:0] {
        H_IDLE    = 2'd0,
        H_WRITE   = 2'd1,
        H_RD_DATA = 2'd2,
        H_RD_STAT = 2'd3
    } hst_t;

    localparam logic [AW-1:0] LA_BUF  = 2'd0;
    localparam logic [AW-1:0] LA_STAT = 2'd1;
    localparam logic [AW-1:0] LA_CTRL = 2'd2;

    localparam int CB_EN  = 0;
    localparam int CB_DMA = 1;
    localparam int CB_IBI = 2;
endpackage

// File: rtl/hsp_host_fsm.sv
module hsp_host_fsm
    import hsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic hrd_n,
    input  logic hwr_n,
    input  logic ha0,
    output logic cap,
    output logic rd_done
);
    hst_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= H_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            H_IDLE: begin
                if (sel && !hwr_n)      state_d = H_WRITE;
                else if (sel && !hrd_n) state_d = ha0 ? H_RD_STAT : H_RD_DATA;
            end
            H_WRITE:   if (hwr_n || !sel) state_d = H_IDLE;
            H_RD_DATA: if (hrd_n || !sel) state_d = H_IDLE;
            H_RD_STAT: if (hrd_n || !sel) state_d = H_IDLE;
        endcase
    end

    always_comb begin
        cap     = 1'b0;
        rd_done = 1'b0;
        unique case (state_q)
            H_IDLE:    cap     = sel && !hwr_n;
            H_RD_DATA: rd_done = hrd_n || !sel;
            default: ;
        endcase
    end

    // one capture per strobe: a capture is never followed by another capture
    assert_single_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !cap);
endmodule

// File: rtl/hsp_regs.sv
module hsp_regs
    import hsp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic          rd_done,
    input  logic          tag_in,
    input  logic [DW-1:0] hdin,
    input  logic          lwr_en,
    input  logic          lrd_en,
    input  logic [AW-1:0] laddr,
    input  logic [DW-1:0] lwdata,
    output logic [DW-1:0] lrdata,
    output logic [DW-1:0] status,
    output logic [DW-1:0] outbuf,
    output logic          ibf,
    output logic          obf,
    output logic          en,
    output logic          dma_en,
    output logic          ibi_en
);
    logic [DW-1:0]  inbuf_q;
    logic [STW-1:0] gp_q;
    logic           tag_q, f0_q;

    logic lw_buf, lw_stat, lw_ctrl, lr_buf;
    assign lw_buf  = lwr_en && (laddr == LA_BUF);
    assign lw_stat = lwr_en && (laddr == LA_STAT);
    assign lw_ctrl = lwr_en && (laddr == LA_CTRL);
    assign lr_buf  = lrd_en && (laddr == LA_BUF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inbuf_q <= '0;
            tag_q   <= 1'b0;
            ibf     <= 1'b0;
        end else if (cap) begin
            inbuf_q <= hdin;
            tag_q   <= tag_in;
            ibf     <= 1'b1;
        end else if (lr_buf) begin
            ibf     <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outbuf <= '0;
            obf    <= 1'b0;
        end else if (lw_buf) begin
            outbuf <= lwdata;
            obf    <= 1'b1;
        end else if (rd_done) begin
            obf    <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_q <= '0;
            f0_q <= 1'b0;
        end else if (lw_stat) begin
            gp_q <= lwdata[DW-1:4];
            f0_q <= lwdata[2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en     <= 1'b0;
            dma_en <= 1'b0;
            ibi_en <= 1'b0;
        end else if (lw_ctrl) begin
            en <= lwdata[CB_EN];
            if (en) begin
                dma_en <= lwdata[CB_DMA];
                ibi_en <= lwdata[CB_IBI];
            end
        end
    end

    assign status = {gp_q, tag_q, f0_q, ibf, obf};

    always_comb begin
        unique case (laddr)
            LA_BUF:  lrdata = inbuf_q;
            LA_STAT: lrdata = status;
            LA_CTRL: lrdata = {{(DW-3){1'b0}}, ibi_en, dma_en, en};
            default: lrdata = '0;
        endcase
    end

    assert_ibf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> ibf);
    assert_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (status[3] == $past(tag_in)));
    assert_ibf_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_buf && !cap) |=> !ibf);
    assert_obf_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !lw_buf) |=> !obf);
    assert_ctrl_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_ctrl && !en) |=> ($stable(dma_en) && $stable(ibi_en)));
    assert_ibf_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && lr_buf) |=> ibf);
endmodule

// File: rtl/hsp_port.sv
module hsp_port
    import hsp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hcs_n,
    input  logic          hrd_n,
    input  logic          hwr_n,
    input  logic          ha0,
    input  logic          hdack_n,
    input  logic [DW-1:0] hdin,
    output logic [DW-1:0] hdout,
    output logic          hdrq,
    output logic          hibf,
    output logic          hobf,
    input  logic          lwr_en,
    input  logic          lrd_en,
    input  logic [AW-1:0] laddr,
    input  logic [DW-1:0] lwdata,
    output logic [DW-1:0] lrdata,
    output logic          lirq
);
    logic          sel, cap, rd_done;
    logic [DW-1:0] status, outbuf;
    logic          ibf, obf, en, dma_en, ibi_en;

    assign sel = en && (!hcs_n || (dma_en && !hdack_n));

    hsp_host_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .hrd_n   (hrd_n),
        .hwr_n   (hwr_n),
        .ha0     (ha0),
        .cap     (cap),
        .rd_done (rd_done)
    );

    hsp_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (cap),
        .rd_done (rd_done),
        .tag_in  (ha0),
        .hdin    (hdin),
        .lwr_en  (lwr_en),
        .lrd_en  (lrd_en),
        .laddr   (laddr),
        .lwdata  (lwdata),
        .lrdata  (lrdata),
        .status  (status),
        .outbuf  (outbuf),
        .ibf     (ibf),
        .obf     (obf),
        .en      (en),
        .dma_en  (dma_en),
        .ibi_en  (ibi_en)
    );

    assign hdout = ha0 ? status : outbuf;
    assign hibf  = ibf;
    assign hobf  = obf;
    assign hdrq  = en && dma_en && obf;
    assign lirq  = ibf && ibi_en;

    assert_drq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hdrq |-> hobf);
    assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lirq |-> hibf);
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(hibf));
endmodule

// File: tb/sim_hsp_port.sv
module sim_hsp_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hcs_n = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1, ha0 = 1'b0, hdack_n = 1'b1;
    logic [7:0] hdin = '0;
    logic [7:0] hdout;
    logic       hdrq, hibf, hobf;
    logic       lwr_en = 1'b0, lrd_en = 1'b0;
    logic [1:0] laddr = '0;
    logic [7:0] lwdata = '0;
    logic [7:0] lrdata;
    logic       lirq;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] v;

    always #10 clk = ~clk;

    hsp_port u0 (
        .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
        .ha0(ha0), .hdack_n(hdack_n), .hdin(hdin), .hdout(hdout), .hdrq(hdrq),
        .hibf(hibf), .hobf(hobf), .lwr_en(lwr_en), .lrd_en(lrd_en), .laddr(laddr),
        .lwdata(lwdata), .lrdata(lrdata), .lirq(lirq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a0, input logic [7:0] d);
        @(negedge clk); hcs_n = 0; hwr_n = 0; ha0 = a0; hdin = d;
        @(negedge clk);
        @(negedge clk); hcs_n = 1; hwr_n = 1;
        @(negedge clk);
    endtask

    task automatic host_read(input logic a0, output logic [7:0] d);
        @(negedge clk); hcs_n = 0; hrd_n = 0; ha0 = a0;
        @(negedge clk); d = hdout; hcs_n = 1; hrd_n = 1;
        @(negedge clk);
    endtask

    task automatic local_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); lwr_en = 1; laddr = a; lwdata = d;
        @(negedge clk); lwr_en = 0;
    endtask

    task automatic local_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); lrd_en = 1; laddr = a; #1 d = lrdata;
        @(negedge clk); lrd_en = 0;
    endtask

    task automatic t_reset;
        check("R1 hibf", {7'b0, hibf}, 8'h00);
        check("R1 hobf", {7'b0, hobf}, 8'h00);
        check("R1 hdrq/lirq", {6'b0, hdrq, lirq}, 8'h00);
        local_rd(2'd2, v); check("R1 control", v, 8'h00);
        local_rd(2'd1, v); check("R1 status", v, 8'h00);
    endtask

    task automatic t_disabled;
        host_write(1'b0, 8'hA5);
        check("R10 ibf while disabled", {7'b0, hibf}, 8'h00);
    endtask

    task automatic t_ctrl_lock;
        local_wr(2'd2, 8'h06); local_rd(2'd2, v); check("R9 locked write", v, 8'h00);
        local_wr(2'd2, 8'h07); local_rd(2'd2, v); check("R9 enable only", v, 8'h01);
        local_wr(2'd2, 8'h07); local_rd(2'd2, v); check("R9 unlocked write", v, 8'h07);
        local_wr(2'd2, 8'h01); local_rd(2'd2, v); check("R9 plain mode", v, 8'h01);
    endtask

    task automatic t_host_write;
        host_write(1'b0, 8'h5A);
        check("R2 hibf set", {7'b0, hibf}, 8'h01);
        host_read(1'b1, v); check("R3 data tag status", v, 8'h02);
        local_rd(2'd0, v); check("R4 inbound byte", v, 8'h5A);
        check("R4 ibf cleared", {7'b0, hibf}, 8'h00);
        host_write(1'b1, 8'hC3);
        host_read(1'b1, v); check("R3 command tag status", v, 8'h0A);
        local_rd(2'd0, v); check("R2 command byte", v, 8'hC3);
    endtask

    task automatic t_status;
        local_wr(2'd1, 8'hF4);
        host_read(1'b1, v); check("R6 status byte", v, 8'hFC);
    endtask

    task automatic t_outbound;
        local_wr(2'd0, 8'h3C);
        check("R5 hobf set", {7'b0, hobf}, 8'h01);
        check("R7 no drq without dma", {7'b0, hdrq}, 8'h00);
        host_read(1'b0, v); check("R5 host data", v, 8'h3C);
        check("R5 hobf cleared", {7'b0, hobf}, 8'h00);
    endtask

    task automatic t_irq;
        local_wr(2'd2, 8'h05);
        host_write(1'b0, 8'h77);
        check("R8 irq raised", {7'b0, lirq}, 8'h01);
        local_rd(2'd0, v);
        check("R8 irq dropped", {7'b0, lirq}, 8'h00);
        local_wr(2'd2, 8'h01);
        host_write(1'b0, 8'h12);
        check("R8 irq gated", {7'b0, lirq}, 8'h00);
        local_rd(2'd0, v);
    endtask

    task automatic t_dma;
        local_wr(2'd2, 8'h03);
        check("R7 drq idle", {7'b0, hdrq}, 8'h00);
        local_wr(2'd0, 8'h99);
        check("R7 drq raised", {7'b0, hdrq}, 8'h01);
        @(negedge clk); hdack_n = 0; hrd_n = 0; ha0 = 0;
        @(negedge clk); check("R7 dack data", hdout, 8'h99); hdack_n = 1; hrd_n = 1;
        @(negedge clk);
        check("R7 drq dropped", {6'b0, hdrq, hobf}, 8'h00);
        local_wr(2'd2, 8'h01);
    endtask

    task automatic t_collide_in;
        host_write(1'b0, 8'h11);
        @(negedge clk); hcs_n = 0; hwr_n = 0; ha0 = 0; hdin = 8'h22;
        lrd_en = 1; laddr = 2'd0; #1 v = lrdata;
        check("R11 old byte read", v, 8'h11);
        @(negedge clk); lrd_en = 0; hcs_n = 1; hwr_n = 1;
        @(negedge clk);
        check("R11 ibf kept", {7'b0, hibf}, 8'h01);
        local_rd(2'd0, v); check("R11 new byte", v, 8'h22);
    endtask

    task automatic t_collide_out;
        local_wr(2'd0, 8'h44);
        @(negedge clk); hcs_n = 0; hrd_n = 0; ha0 = 0;
        @(negedge clk); check("R12 first byte", hdout, 8'h44);
        hcs_n = 1; hrd_n = 1; lwr_en = 1; laddr = 2'd0; lwdata = 8'h55;
        @(negedge clk); lwr_en = 0;
        check("R12 obf kept", {7'b0, hobf}, 8'h01);
        host_read(1'b0, v); check("R12 new byte", v, 8'h55);
        check("R12 obf cleared", {7'b0, hobf}, 8'h00);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_ctrl_lock();
        t_host_write();
        t_status();
        t_outbound();
        t_irq();
        t_dma();
        t_collide_in();
        t_collide_out();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule